// File: doc/BRIEF.md
# Two-wire serial bus master byte engine

This block is the master side of a two-wire serial bus (clock line and data line, both open-drain with pull-ups). It derives the bus clock from the system clock and carries out one bus-level command at a time: start, repeated start, write one byte, read one byte, and stop. Both lines leave the block as drive-low enables. The data line is read back through a single input.

A user sequences whole transfers by issuing commands over a valid/ready handshake. Each byte command ends with a one-cycle response that carries the eight bits seen on the bus and the level of the ninth (acknowledge) bit. Between commands the engine holds the clock line low, so any number of bytes may follow a start before the stop. The clock half-period is set in system clock cycles by an input. That input is captured when a command is accepted.

Top module: `tw_byte_master`

## Requirements
- R1: After reset, both drive-low outputs are 0 (lines released), `cmdReady` is 1 and `rspValid` is 0.
- R2: Every bus-clock high and low phase lasts H system cycles, where H is `divHalf` captured at command acceptance, raised to 4 if it is smaller.
- R3: Op code 0 (start) pulls the data line low while the clock line is high, then pulls the clock line low. Op code 1 (repeated start) releases the data line while the clock is low, releases the clock, pulls the data line low while the clock is high, and then pulls the clock low.
- R4: Op code 4 (stop) pulls the data line low while the clock is low, releases the clock, then releases the data line, which leaves both lines high.
- R5: Op code 2 (write) sends `cmdData` MSB first on eight clock pulses, with the data line changing only while the clock is low. The master releases the data line for a ninth pulse. `rspAck` is the data-line level sampled at the ninth rising edge (0 = acknowledged), and `rspData` holds the eight data bits seen on the bus.
- R6: Op code 3 (read) releases the data line for eight pulses and samples it at each rising clock edge, MSB first, into `rspData`. On the ninth pulse the master drives the line low when `cmdNack` is 0 and leaves it high when `cmdNack` is 1. `rspAck` reports that ninth-bit level.
- R7: Each byte command produces exactly one `rspValid` pulse of one cycle, in order. In that cycle `cmdReady` is already 1, so byte commands may run back to back without limit.
- R8: Op codes 5 to 7 are accepted, leave both drive-low outputs unchanged and produce no response.
- R9: `cmdReady` is 0 from the cycle after acceptance until the command completes. The clock and data drive outputs never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divHalf | input | 16 | Bus-clock half-period in system cycles (minimum 4) |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Engine idle; command accepted when both are high |
| cmdOp | input | 3 | Op code: 0 start, 1 repeated start, 2 write, 3 read, 4 stop |
| cmdData | input | 8 | Byte to write |
| cmdNack | input | 1 | Read: 1 leaves the ninth bit high (last byte) |
| rspValid | output | 1 | One-cycle response pulse after a byte command |
| rspData | output | 8 | Byte seen on the bus |
| rspAck | output | 1 | Ninth-bit level, 0 = acknowledge |
| sclDriveLow | output | 1 | Pull clock line low when 1 |
| sdaDriveLow | output | 1 | Pull data line low when 1 |
| sdaIn | input | 1 | Data line level as seen on the bus |

## Verification
The response pulse of one byte command and the acceptance of the next command fall in the same cycle. This happens because the engine becomes ready at the same edge that raises `rspValid`. The bench provokes this by keeping `cmdValid` high across consecutive commands. A response monitor requires `cmdReady` to be high whenever `rspValid` is seen. A bus monitor decodes start, stop and nine-bit byte events from the line levels and compares them, in order, with the queue the driver filled. So an accepted command that is lost, doubled or reordered shows up as a mismatch.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam logic [2:0] OP_START   = 3'd0;
  localparam logic [2:0] OP_RESTART = 3'd1;
  localparam logic [2:0] OP_WRITE   = 3'd2;
  localparam logic [2:0] OP_READ    = 3'd3;
  localparam logic [2:0] OP_STOP    = 3'd4;

  typedef struct packed {
    logic load;
    logic sclPull;
    logic sclFree;
    logic sdaPull;
    logic sdaFree;
    logic sdaData;
    logic sdaAck;
    logic sampleData;
    logic sampleAck;
    logic fire;
  } twStrobe_t;
endpackage

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_W   = 16,
  parameter int MIN_HALF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [HALF_W-1:0] divHalf,
  output logic              cmdReady,
  output logic [2:0]        curOp,
  output twStrobe_t         stb
);
  localparam int LAST_BYTE = 2 * DATA_W + 2;
  localparam int STEP_W = $clog2(LAST_BYTE + 1);
  localparam logic [STEP_W-1:0] BITS_S = STEP_W'(DATA_W);
  localparam logic [STEP_W-1:0] LAST_S = STEP_W'(LAST_BYTE);
  localparam logic [HALF_W-1:0] HALF_FLOOR = HALF_W'(MIN_HALF);

  logic busy;
  logic [2:0] op;
  logic [STEP_W-1:0] step, lastStep, bitIdx;
  logic [HALF_W-1:0] cnt, halfReg;
  logic accept, phaseEnd, edgeA, edgeB, isByte;

  assign accept   = cmdValid && !busy;
  assign cmdReady = !busy;
  assign curOp    = op;
  assign phaseEnd = busy && (cnt == halfReg - 1'b1);
  assign edgeA    = busy && (cnt == '0);
  assign edgeB    = busy && (cnt == HALF_W'(1));
  assign bitIdx   = step >> 1;
  assign isByte   = busy && ((op == OP_WRITE) || (op == OP_READ));

  always_comb begin
    case (op)
      OP_START:          lastStep = STEP_W'(1);
      OP_RESTART:        lastStep = STEP_W'(3);
      OP_STOP:           lastStep = STEP_W'(2);
      OP_WRITE, OP_READ: lastStep = LAST_S;
      default:           lastStep = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      op      <= OP_START;
      step    <= '0;
      cnt     <= '0;
      halfReg <= HALF_FLOOR;
    end else if (accept) begin
      busy    <= 1'b1;
      op      <= cmdOp;
      step    <= '0;
      cnt     <= '0;
      halfReg <= (divHalf < HALF_FLOOR) ? HALF_FLOOR : divHalf;
    end else if (busy) begin
      if (phaseEnd) begin
        cnt <= '0;
        if (step == lastStep) busy <= 1'b0;
        else step <= step + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb      = '0;
    stb.load = accept;
    stb.fire = isByte && phaseEnd && (step == lastStep);
    if (busy) begin
      case (op)
        OP_START: begin
          if (step == '0 && edgeA) stb.sdaPull = 1'b1;
          if (step == STEP_W'(1) && edgeA) stb.sclPull = 1'b1;
        end
        OP_RESTART: begin
          if (step == '0 && edgeB) stb.sdaFree = 1'b1;
          if (step == STEP_W'(1) && edgeA) stb.sclFree = 1'b1;
          if (step == STEP_W'(2) && edgeA) stb.sdaPull = 1'b1;
          if (step == STEP_W'(3) && edgeA) stb.sclPull = 1'b1;
        end
        OP_STOP: begin
          if (step == '0 && edgeB) stb.sdaPull = 1'b1;
          if (step == STEP_W'(1) && edgeA) stb.sclFree = 1'b1;
          if (step == STEP_W'(2) && edgeA) stb.sdaFree = 1'b1;
        end
        OP_WRITE, OP_READ: begin
          if (!step[0]) begin
            if (edgeA) stb.sclPull = 1'b1;
            if (edgeB && bitIdx < BITS_S) stb.sdaData = 1'b1;
            if (edgeB && bitIdx == BITS_S) stb.sdaAck = 1'b1;
          end else if (edgeA) begin
            stb.sclFree = 1'b1;
            if (bitIdx < BITS_S) stb.sampleData = 1'b1;
            else stb.sampleAck = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt < halfReg)); // R2
  AST_HALF_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (halfReg >= HALF_FLOOR)); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady); // R9
endmodule

// File: rtl/tw_dpath.sv
module tw_dpath
  import tw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  twStrobe_t         stb,
  input  logic [2:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              cmdNack,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspAck
);
  logic [DATA_W-1:0] shiftReg;
  logic sclLow, sdaLow, nackReg, isRead, ackBit;

  assign sclDriveLow = sclLow;
  assign sdaDriveLow = sdaLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      nackReg  <= 1'b0;
      isRead   <= 1'b0;
      ackBit   <= 1'b1;
    end else begin
      if (stb.load) begin
        shiftReg <= (cmdOp == OP_READ) ? '1 : cmdData;
        nackReg  <= cmdNack;
        isRead   <= (cmdOp == OP_READ);
      end else if (stb.sampleData) begin
        shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
      end
      if (stb.sampleAck) ackBit <= sdaIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclLow <= 1'b0;
      sdaLow <= 1'b0;
    end else begin
      if (stb.sclPull) sclLow <= 1'b1;
      else if (stb.sclFree) sclLow <= 1'b0;
      if (stb.sdaPull) sdaLow <= 1'b1;
      else if (stb.sdaFree) sdaLow <= 1'b0;
      else if (stb.sdaData) sdaLow <= !shiftReg[DATA_W-1];
      else if (stb.sdaAck) sdaLow <= isRead && !nackReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      rspAck   <= 1'b1;
    end else begin
      rspValid <= stb.fire;
      if (stb.fire) begin
        rspData <= shiftReg;
        rspAck  <= ackBit;
      end
    end
  end

  AST_LINES_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(!$stable(sclLow) && !$stable(sdaLow))); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7
endmodule

// File: rtl/tw_byte_master.sv
module tw_byte_master
  import tw_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_W   = 16,
  parameter int MIN_HALF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALF_W-1:0] divHalf,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              cmdNack,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspAck,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic              sdaIn
);
  twStrobe_t stb;
  logic [2:0] curOp;

  tw_ctrl #(.DATA_W(DATA_W), .HALF_W(HALF_W), .MIN_HALF(MIN_HALF)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .divHalf(divHalf), .cmdReady(cmdReady), .curOp(curOp), .stb(stb)
  );

  tw_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdOp(cmdOp), .cmdData(cmdData),
    .cmdNack(cmdNack), .sdaIn(sdaIn), .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow), .rspValid(rspValid), .rspData(rspData),
    .rspAck(rspAck)
  );

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdReady && (curOp == OP_WRITE || curOp == OP_READ) &&
     !sclDriveLow && $past(!sclDriveLow)) |-> $stable(sdaDriveLow)); // R5
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdReady && curOp > OP_STOP) |-> ($stable(sclDriveLow) && $stable(sdaDriveLow) && !rspValid)); // R8
endmodule

// File: tb/tb_tw_byte_master.sv
`timescale 1ns/1ps
module tb_tw_byte_master;
  localparam int EV_S = 32'h1000;
  localparam int EV_P = 32'h2000;
  localparam int EV_B = 32'h4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] divHalf = 16'd6;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [2:0] cmdOp = 3'd0;
  logic [7:0] cmdData = 8'h00;
  logic cmdNack = 1'b0;
  logic rspValid;
  logic [7:0] rspData;
  logic rspAck;
  logic sclDriveLow, sdaDriveLow, sdaIn;

  int total = 0;
  int bad = 0;
  int busQ[$];
  string busTagQ[$];
  int rspQ[$];
  string rspTagQ[$];

  logic slvEn = 1'b0;
  logic [7:0] slvByte = 8'hFF;
  logic slvAckLow = 1'b0;
  int curBit = 15;
  int bitCnt = 0;
  logic [8:0] shiftReg = '0;
  int cyc = 0;
  int hiStart = 0;
  int lastHigh = 0;
  logic prevScl = 1'b1;
  logic prevSda = 1'b1;
  logic slaveLow, sclBus, sdaBus;

  always #10 clk = ~clk;

  assign slaveLow = slvEn && ((curBit < 8) ? !slvByte[7 - curBit] :
                              ((curBit == 8) ? slvAckLow : 1'b0));
  assign sclBus = !sclDriveLow;
  assign sdaBus = !(sdaDriveLow || slaveLow);
  assign sdaIn  = sdaBus;

  tw_byte_master dut (
    .clk(clk), .rstN(rstN), .divHalf(divHalf), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdData(cmdData), .cmdNack(cmdNack),
    .rspValid(rspValid), .rspData(rspData), .rspAck(rspAck),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .sdaIn(sdaIn)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic popBus(input int ev);
    if (busQ.size() == 0) chk("R7", ev, 0, "unexpected bus event");
    else chk(busTagQ.pop_front(), ev, busQ.pop_front(), "bus event");
  endtask

  // Bus and response monitor
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevScl && sclBus && prevSda && !sdaBus) begin
        popBus(EV_S); bitCnt = 0; curBit = 15;
      end else if (prevScl && sclBus && !prevSda && sdaBus) begin
        popBus(EV_P); bitCnt = 0; curBit = 15;
      end
      if (!prevScl && sclBus) begin
        shiftReg = {shiftReg[7:0], sdaBus};
        bitCnt++;
        hiStart = cyc;
        if (bitCnt == 9) begin
          popBus(EV_B | int'(shiftReg));
          bitCnt = 0;
        end
      end
      if (prevScl && !sclBus) begin
        curBit = bitCnt;
        lastHigh = cyc - hiStart;
      end
      if (rspValid) begin
        chk("R7", int'(cmdReady), 1, "ready with response");
        if (rspQ.size() == 0) chk("R7", int'({rspData, rspAck}), 0, "unexpected response");
        else chk(rspTagQ.pop_front(), int'({rspData, rspAck}), rspQ.pop_front(), "response");
      end
    end
    prevScl = sclBus;
    prevSda = sdaBus;
  end

  // Driver: called at a negedge, returns at the negedge after acceptance
  task automatic issue(input logic [2:0] op, input logic [7:0] data, input logic nack,
                       input logic [7:0] slvVal, input logic slvAck);
    cmdOp = op; cmdData = data; cmdNack = nack; cmdValid = 1'b1;
    case (op)
      3'd0, 3'd1: begin busQ.push_back(EV_S); busTagQ.push_back("R3"); end
      3'd4: begin busQ.push_back(EV_P); busTagQ.push_back("R4"); end
      3'd2: begin
        busQ.push_back(EV_B | int'({data, !slvAck})); busTagQ.push_back("R5");
        rspQ.push_back(int'({data, !slvAck})); rspTagQ.push_back("R5");
      end
      3'd3: begin
        busQ.push_back(EV_B | int'({slvVal, nack})); busTagQ.push_back("R6");
        rspQ.push_back(int'({slvVal, nack})); rspTagQ.push_back("R6");
      end
      default: ;
    endcase
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    slvEn = (op == 3'd2) || (op == 3'd3);
    slvByte = (op == 3'd3) ? slvVal : 8'hFF;
    slvAckLow = (op == 3'd2) ? slvAck : 1'b0;
    chk("R9", int'(cmdReady), 0, "busy after accept");
  endtask

  task automatic waitIdle();
    while (!cmdReady) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic s0, d0, moved;
    repeat (4) @(negedge clk);
    chk("R1", int'(sclDriveLow), 0, "scl released in reset");
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", int'(sdaDriveLow), 0, "sda released");
    chk("R1", int'(sclDriveLow), 0, "scl released");
    chk("R1", int'(cmdReady), 1, "ready");
    chk("R1", int'(rspValid), 0, "no response");

    divHalf = 16'd6;
    issue(3'd0, 8'h00, 1'b0, 8'hFF, 1'b0);
    issue(3'd2, 8'hA5, 1'b0, 8'hFF, 1'b1);
    issue(3'd2, 8'h3C, 1'b0, 8'hFF, 1'b0);
    issue(3'd3, 8'h00, 1'b0, 8'h96, 1'b0);
    issue(3'd3, 8'h00, 1'b1, 8'h4B, 1'b0);
    waitIdle();
    chk("R2", lastHigh, 6, "high phase at divider 6");
    issue(3'd1, 8'h00, 1'b0, 8'hFF, 1'b0);
    issue(3'd2, 8'h00, 1'b0, 8'hFF, 1'b1);
    waitIdle();
    @(negedge clk);
    // R8: unknown op code keeps lines still and gives no response
    s0 = sclDriveLow; d0 = sdaDriveLow; moved = 1'b0;
    issue(3'd6, 8'h55, 1'b0, 8'hFF, 1'b0);
    while (!cmdReady) begin
      if (sclDriveLow !== s0 || sdaDriveLow !== d0) moved = 1'b1;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    if (sclDriveLow !== s0 || sdaDriveLow !== d0) moved = 1'b1;
    chk("R8", int'(moved), 0, "lines moved on unknown op");
    issue(3'd3, 8'h00, 1'b1, 8'hFF, 1'b0);
    issue(3'd4, 8'h00, 1'b0, 8'hFF, 1'b0);
    waitIdle();
    @(negedge clk);
    chk("R4", int'({sclDriveLow, sdaDriveLow}), 0, "bus idle after stop");

    divHalf = 16'd2;
    issue(3'd0, 8'h00, 1'b0, 8'hFF, 1'b0);
    issue(3'd2, 8'hFF, 1'b0, 8'hFF, 1'b1);
    waitIdle();
    chk("R2", lastHigh, 4, "high phase floor");
    issue(3'd4, 8'h00, 1'b0, 8'hFF, 1'b0);
    waitIdle();

    divHalf = 16'd9;
    issue(3'd0, 8'h00, 1'b0, 8'hFF, 1'b0);
    issue(3'd2, 8'h81, 1'b0, 8'hFF, 1'b1);
    issue(3'd3, 8'h00, 1'b1, 8'h7E, 1'b0);
    waitIdle();
    chk("R2", lastHigh, 9, "high phase at divider 9");
    issue(3'd4, 8'h00, 1'b0, 8'hFF, 1'b0);
    waitIdle();
    repeat (20) @(negedge clk);

    chk("R7", busQ.size(), 0, "bus events outstanding");
    chk("R7", rspQ.size(), 0, "responses outstanding");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule